// File: doc/BRIEF.md
# AES-128 Memory-Mapped Encryption Coprocessor

This block performs AES-128 encryption in electronic-codebook fashion. It sits on a 32-bit processor bus. Software sees it as three word locations: a data word register, a command register and a result word register. A 128-bit key or plaintext is built by writing a word to the data register and then committing it with a load command. Four such pairs fill one register. A single encrypt command then runs the whole cipher in hardware. The 128-bit ciphertext comes back one word at a time: each read command moves the next word into the result register.

The key register keeps its value after a block completes, so software loads the key once and then streams plaintext blocks through. The cipher runs one round per clock, with the round keys expanded on the fly. A controller with three states sequences it:
- **IDLE**: waiting for work.
- **MID**: rounds 1 to 9, each with column mixing.
- **LAST**: round 10, without column mixing.

The transitions are:
- IDLE to MID on an accepted encrypt command.
- MID to MID while the round counter is below 9.
- MID to LAST when the counter reaches 9.
- LAST to IDLE unconditionally, which loads the result.

Software polls a busy bit to learn when the result is ready. While a block is running, software may already load the next plaintext.

Top module: `aes_ecb_cop`

## Requirements
- R1: After reset, reads of offset 0, offset 1 and offset 2 all return 0 (not busy, no data, no result).
- R2: A write to offset 0 stores the word, and a read of offset 0 returns the last word written there.
- R3: A command write to offset 1 decodes bits [2:0]. Code 1 shifts the stored data word into the low end of the 128-bit plaintext register, and code 2 does the same for the key register. Earlier words move toward the top, so after four loads the first word occupies bits [127:96] (FIPS-197 byte order). A fifth load pushes out the oldest word.
- R4: Code 3 (encrypt) written while idle sets bit 0 of offset 1 (busy) from the next cycle. Busy stays 1 for exactly 10 cycles and then returns to 0.
- R5: The ciphertext equals AES-128 of the plaintext under the key. For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff it is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R6: Code 4 (read output) written while idle makes offset 2 show the next 32-bit ciphertext word from the next cycle, most significant word first. A fifth such command wraps around to the first word again.
- R7: An encrypt command written while busy is ignored. The running block is neither restarted nor lengthened, and its result is unchanged.
- R8: A read-output command written while busy is ignored. Offset 2 keeps its value and the word pointer does not advance.
- R9: Plaintext loads during a running block do not disturb that block's result, and the next encrypt uses the newly loaded plaintext.
- R10: The key is retained after an encryption, so later blocks encrypt correctly without reloading it.
- R11: Command codes 0, 5, 6 and 7, and writes to offsets 2 and 3, change no state. Offset 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (2) | Word offset: 0 data, 1 command/status, 2 result |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for the current offset (combinational) |

## Verification
The cipher is tried with the published FIPS-197 vector, which anchors the byte and word ordering, and with seeded random keys and plaintexts. The random runs sometimes keep the key and sometimes replace it, which separates a retained key from a stale or corrupted one. Directed patterns overlap commands with a running block: a second encrypt, a read-output and four plaintext loads. These tell apart a controller that ignores such commands from one that restarts, shifts its result pointer early or lets new plaintext leak into the block in flight. A five-word load and a five-word readback expose whether the shift registers drop and wrap words in the stated order.

// File: rtl/aes_cop_pkg.sv
`timescale 1ns/1ps
package aes_cop_pkg;

    localparam int AES_BLK_W  = 128;
    localparam int AES_ROUNDS = 10;
    localparam int OP_W       = 3;

    localparam logic [OP_W-1:0] OP_LOAD_DATA = 3'd1;
    localparam logic [OP_W-1:0] OP_LOAD_KEY  = 3'd2;
    localparam logic [OP_W-1:0] OP_ENCRYPT   = 3'd3;
    localparam logic [OP_W-1:0] OP_READ_OUT  = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MID  = 2'd1,
        S_LAST = 2'd2
    } run_state_e;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_xtime(p);
        end
        return acc;
    endfunction

    // inverse as a^254; maps 0 to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = a;
        e = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] sbox_fn(input logic [7:0] a);
        logic [7:0] v;
        logic [7:0] y;
        logic [7:0] c;
        v = gf_inv(a);
        c = 8'h63;
        for (int i = 0; i < 8; i++) begin
            y[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^
                   v[(i + 6) % 8] ^ v[(i + 7) % 8] ^ c[i];
        end
        return y;
    endfunction

endpackage

// File: rtl/aes_cop_sbox.sv
`timescale 1ns/1ps
module aes_cop_sbox (
    input  logic [7:0] byte_i,
    output logic [7:0] byte_o
);
    import aes_cop_pkg::*;

    always_comb begin
        byte_o = sbox_fn(byte_i);
    end

endmodule

// File: rtl/aes_cop_keyexp.sv
`timescale 1ns/1ps
module aes_cop_keyexp (
    input  logic [127:0] rk_i,
    input  logic [7:0]   rcon_i,
    output logic [127:0] rk_o
);
    import aes_cop_pkg::*;

    localparam int WORD_W = 32;
    localparam int NBYTE  = WORD_W / 8;

    logic [WORD_W-1:0] tail_w;
    logic [WORD_W-1:0] rot_w;
    logic [7:0]        sub_b [NBYTE];
    logic [7:0]        rot_b [NBYTE];
    logic [WORD_W-1:0] mix_w;
    logic [WORD_W-1:0] n0, n1, n2, n3;

    assign tail_w = rk_i[WORD_W-1:0];
    assign rot_w  = {tail_w[WORD_W-9:0], tail_w[WORD_W-1 -: 8]};

    genvar j;
    generate
        for (j = 0; j < NBYTE; j++) begin : g_sub
            assign rot_b[j] = rot_w[WORD_W-1-8*j -: 8];
            aes_cop_sbox u_sb (.byte_i(rot_b[j]), .byte_o(sub_b[j]));
        end
    endgenerate

    assign mix_w = {sub_b[0] ^ rcon_i, sub_b[1], sub_b[2], sub_b[3]};
    assign n0    = rk_i[127:96] ^ mix_w;
    assign n1    = rk_i[95:64]  ^ n0;
    assign n2    = rk_i[63:32]  ^ n1;
    assign n3    = tail_w       ^ n2;
    assign rk_o  = {n0, n1, n2, n3};

endmodule

// File: rtl/aes_cop_round.sv
`timescale 1ns/1ps
module aes_cop_round (
    input  logic [127:0] st_i,
    input  logic [127:0] rk_i,
    input  logic         last_i,
    output logic [127:0] st_o
);
    import aes_cop_pkg::*;

    localparam int NB = 16;

    logic [7:0] in_b  [NB];
    logic [7:0] sub_b [NB];
    logic [7:0] sr_b  [NB];
    logic [7:0] mc_b  [NB];

    genvar i, c, r;
    generate
        for (i = 0; i < NB; i++) begin : g_sub
            assign in_b[i] = st_i[127-8*i -: 8];
            aes_cop_sbox u_sb (.byte_i(in_b[i]), .byte_o(sub_b[i]));
        end
        // row r of column c takes the byte from column (c+r) mod 4
        for (c = 0; c < 4; c++) begin : g_col
            for (r = 0; r < 4; r++) begin : g_row
                assign sr_b[r + 4*c] = sub_b[r + 4*((c + r) % 4)];
            end
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = sr_b[4*k];
            a1 = sr_b[4*k+1];
            a2 = sr_b[4*k+2];
            a3 = sr_b[4*k+3];
            mc_b[4*k]   = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
            mc_b[4*k+1] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
            mc_b[4*k+2] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
            mc_b[4*k+3] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
        end
    end

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            st_o[127-8*k -: 8] = (last_i ? sr_b[k] : mc_b[k]) ^ rk_i[127-8*k -: 8];
        end
    end

endmodule

// File: rtl/aes_ecb_cop.sv
`timescale 1ns/1ps
module aes_ecb_cop #(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    import aes_cop_pkg::*;

    localparam int BLK_W      = AES_BLK_W;
    localparam int NUM_ROUNDS = AES_ROUNDS;
    localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);
    localparam logic [ADDR_W-1:0] OFF_DIN  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_DOUT = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  MID_END  = CNT_W'(NUM_ROUNDS - 1);

    run_state_e         state_q, state_d;
    logic [BUS_W-1:0]   din_q;
    logic [BLK_W-1:0]   pt_q;
    logic [BLK_W-1:0]   key_q;
    logic [BLK_W-1:0]   ct_sh_q;
    logic [BUS_W-1:0]   dout_q;
    logic [BLK_W-1:0]   st_q;
    logic [BLK_W-1:0]   rk_q;
    logic [7:0]         rcon_q;
    logic [CNT_W-1:0]   rnd_q;

    logic               data_wr, cmd_wr;
    logic [OP_W-1:0]    op;
    logic               op_known;
    logic               busy;
    logic               enc_go, rd_go;
    logic [BLK_W-1:0]   rk_next;
    logic [BLK_W-1:0]   round_out;

    // ---------------- command decode ----------------
    assign data_wr  = bus_wr && (bus_addr == OFF_DIN);
    assign cmd_wr   = bus_wr && (bus_addr == OFF_CMD);
    assign op       = bus_wdata[OP_W-1:0];
    assign op_known = (op == OP_LOAD_DATA) || (op == OP_LOAD_KEY) ||
                      (op == OP_ENCRYPT)   || (op == OP_READ_OUT);
    assign enc_go   = cmd_wr && (op == OP_ENCRYPT) && (state_q == S_IDLE);
    assign rd_go    = cmd_wr && (op == OP_READ_OUT) && !busy;

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (enc_go) state_d = S_MID;
            S_MID:   if (rnd_q == MID_END) state_d = S_LAST;
            S_LAST:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign busy = (state_q != S_IDLE);

    // ---------------- round datapath ----------------
    aes_cop_keyexp u_kexp (
        .rk_i   (rk_q),
        .rcon_i (rcon_q),
        .rk_o   (rk_next)
    );

    aes_cop_round u_round (
        .st_i   (st_q),
        .rk_i   (rk_next),
        .last_i (state_q == S_LAST),
        .st_o   (round_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            rk_q   <= '0;
            rcon_q <= 8'h00;
            rnd_q  <= '0;
        end else if (enc_go) begin
            st_q   <= pt_q ^ key_q;
            rk_q   <= key_q;
            rcon_q <= 8'h01;
            rnd_q  <= CNT_W'(1);
        end else if (busy) begin
            st_q   <= round_out;
            rk_q   <= rk_next;
            rcon_q <= gf_xtime(rcon_q);
            rnd_q  <= rnd_q + CNT_W'(1);
        end
    end

    // ---------------- software-visible registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q   <= '0;
            pt_q    <= '0;
            key_q   <= '0;
            ct_sh_q <= '0;
            dout_q  <= '0;
        end else begin
            if (data_wr) din_q <= bus_wdata;
            if (cmd_wr && (op == OP_LOAD_DATA))
                pt_q <= {pt_q[BLK_W-BUS_W-1:0], din_q};
            if (cmd_wr && (op == OP_LOAD_KEY))
                key_q <= {key_q[BLK_W-BUS_W-1:0], din_q};
            if (state_q == S_LAST) begin
                ct_sh_q <= round_out;
            end else if (rd_go) begin
                dout_q  <= ct_sh_q[BLK_W-1 -: BUS_W];
                ct_sh_q <= {ct_sh_q[BLK_W-BUS_W-1:0], ct_sh_q[BLK_W-1 -: BUS_W]};
            end
        end
    end

    always_comb begin
        if (bus_addr == OFF_DIN)       bus_rdata = din_q;
        else if (bus_addr == OFF_CMD)  bus_rdata = {{(BUS_W-1){1'b0}}, busy};
        else if (bus_addr == OFF_DOUT) bus_rdata = dout_q;
        else                           bus_rdata = '0;
    end

    // ---------------- assertions ----------------
    // R4
    enc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_go |=> busy);

    // R4
    last_round_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LAST) |=> !busy);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_LAST) |=> (rnd_q == $past(rnd_q) + CNT_W'(1)));

    // R8
    busy_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && op == OP_READ_OUT) |=> $stable(dout_q));

    // R6
    read_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (dout_q == $past(ct_sh_q[BLK_W-1 -: BUS_W])));

    // R11
    bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !op_known) |=> ($stable(pt_q) && $stable(key_q) && $stable(dout_q)));

endmodule

// File: tb/aes_ecb_cop_tb.sv
`timescale 1ns/1ps
module aes_ecb_cop_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] sb_t [256];

    always #2 clk = ~clk;

    aes_ecb_cop u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_x2(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x = a, y = b, acc = 0;
        while (y != 0) begin
            if (y[0]) acc ^= x;
            x = m_x2(x);
            y = y >> 1;
        end
        return acc;
    endfunction

    function automatic logic [7:0] m_rotl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb_t[x] = inv ^ m_rotl(inv, 1) ^ m_rotl(inv, 2) ^ m_rotl(inv, 3) ^
                      m_rotl(inv, 4) ^ 8'h63;
        end
    endtask

    function automatic logic [127:0] m_aes(input logic [127:0] key, input logic [127:0] pt);
        logic [7:0] s [16];
        logic [7:0] k [16];
        logic [7:0] t [16];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            k[i] = key[127-8*i -: 8];
            s[i] = pt[127-8*i -: 8] ^ k[i];
        end
        for (int rnd = 1; rnd <= 10; rnd++) begin
            logic [7:0] g [4];
            g[0] = sb_t[k[13]] ^ rc; g[1] = sb_t[k[14]];
            g[2] = sb_t[k[15]];      g[3] = sb_t[k[12]];
            for (int j = 0; j < 4; j++) k[j] ^= g[j];
            for (int j = 4; j < 16; j++) k[j] ^= k[j-4];
            rc = m_x2(rc);
            for (int i = 0; i < 16; i++) s[i] = sb_t[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    t[r + 4*c] = s[r + 4*((c + r) % 4)];
            for (int c = 0; c < 4; c++) begin
                if (rnd < 10) begin
                    s[4*c]   = m_mul(t[4*c],2) ^ m_mul(t[4*c+1],3) ^ t[4*c+2] ^ t[4*c+3];
                    s[4*c+1] = t[4*c] ^ m_mul(t[4*c+1],2) ^ m_mul(t[4*c+2],3) ^ t[4*c+3];
                    s[4*c+2] = t[4*c] ^ t[4*c+1] ^ m_mul(t[4*c+2],2) ^ m_mul(t[4*c+3],3);
                    s[4*c+3] = m_mul(t[4*c],3) ^ t[4*c+1] ^ t[4*c+2] ^ m_mul(t[4*c+3],2);
                end else begin
                    for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= k[i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    // ---------------- bus helpers ----------------
    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // caller is at a falling edge; consumes exactly one cycle
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic load_blk(input logic [2:0] opc, input logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, v[127-32*i -: 32]);
            wr(2'd1, {29'd0, opc});
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            rd(2'd1, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
        if (bus_addr != 2'd0) @(negedge clk);
    endtask

    task automatic read_blk(output logic [127:0] blk);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            wr(2'd1, 32'd4);
            rd(2'd2, w);
            blk[127-32*i -: 32] = w;
        end
        @(negedge clk);
    endtask

    task automatic run_block(input logic [127:0] key, input logic [127:0] pt,
                             input bit reload_key, input string req);
        logic [127:0] got;
        if (reload_key) load_blk(3'd2, key);
        load_blk(3'd1, pt);
        wr(2'd1, 32'd3);
        wait_idle();
        read_blk(got);
        check(req, got, m_aes(key, pt));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0]  v;
        logic [127:0] blk;
        logic [127:0] fk, fp, key, pt2, pt3, exp;
        int           cnt;

        void'($urandom(32'd20240611));
        build_sbox();

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 din", 128'(v), 128'd0);
        rd(2'd1, v); check("R1 busy", 128'(v), 128'd0);
        rd(2'd2, v); check("R1 dout", 128'(v), 128'd0);
        @(negedge clk);

        // R2 data word readback
        wr(2'd0, 32'hA5C3_5A3C);
        rd(2'd0, v); check("R2 readback", 128'(v), 128'h0A5C3_5A3C);
        @(negedge clk);

        // R3/R5 published vector; R4 busy window
        fk = 128'h000102030405060708090a0b0c0d0e0f;
        fp = 128'h00112233445566778899aabbccddeeff;
        load_blk(3'd2, fk);
        load_blk(3'd1, fp);
        wr(2'd1, 32'd3);
        cnt = 0;
        rd(2'd1, v);
        while (v[0] && cnt < 50) begin
            cnt++;
            @(negedge clk);
            rd(2'd1, v);
        end
        check("R4 busy cycles", 128'(cnt), 128'd10);
        @(negedge clk);
        read_blk(blk);
        check("R5 FIPS vector", blk, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R6 wrap: a fifth read returns the first word
        wr(2'd1, 32'd4);
        rd(2'd2, v); check("R6 wrap", 128'(v), 128'h69c4e0d8);
        wr(2'd1, 32'd4);
        rd(2'd2, v); check("R6 second after wrap", 128'(v), 128'h6a7b0430);
        @(negedge clk);
        // realign pointer: two more reads bring it back to word 0
        wr(2'd1, 32'd4); wr(2'd1, 32'd4);

        // R3 five loads: oldest word dropped
        key = fk;
        load_blk(3'd1, 128'h11111111_22222222_33333333_44444444);
        wr(2'd0, 32'h55555555); wr(2'd1, 32'd1);
        wr(2'd1, 32'd3);
        wait_idle();
        read_blk(blk);
        check("R3 fifth load shifts", blk, m_aes(key, 128'h22222222_33333333_44444444_55555555));

        // R10 key retained across blocks
        run_block(key, 128'hdeadbeef_01234567_89abcdef_fedcba98, 1'b0, "R10 key retained");

        // R8 read-output while busy ignored
        rd(2'd2, v);
        exp = 128'(v);
        @(negedge clk);
        pt2 = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        load_blk(3'd1, pt2);
        wr(2'd1, 32'd3);
        wr(2'd1, 32'd4);
        rd(2'd2, v); check("R8 dout held", 128'(v), exp);
        @(negedge clk);
        wait_idle();
        read_blk(blk);
        check("R8 pointer not advanced", blk, m_aes(key, pt2));

        // R7 / R9 encrypt and loads while busy
        pt2 = 128'hcafef00d_12121212_34343434_56565656;
        pt3 = 128'h99999999_aaaaaaaa_bbbbbbbb_cccccccc;
        load_blk(3'd1, pt2);
        wr(2'd1, 32'd3);             // accepted
        wr(2'd1, 32'd3);             // ignored while busy
        load_blk(3'd1, pt3);         // eight cycles
        rd(2'd1, v); check("R7 still busy after 9 cycles", 128'(v[0]), 128'd1);
        @(negedge clk);
        rd(2'd1, v); check("R7 not extended", 128'(v[0]), 128'd0);
        @(negedge clk);
        read_blk(blk);
        check("R7 result of first block", blk, m_aes(key, pt2));
        wr(2'd1, 32'd3);
        wait_idle();
        read_blk(blk);
        check("R9 new plaintext used", blk, m_aes(key, pt3));

        // R11 unknown codes and other offsets
        rd(2'd2, v);
        exp = 128'(v);
        @(negedge clk);
        wr(2'd1, 32'd0); wr(2'd1, 32'd5); wr(2'd1, 32'd6); wr(2'd1, 32'd7);
        wr(2'd2, 32'h12345678); wr(2'd3, 32'h9abcdef0);
        rd(2'd2, v); check("R11 dout unchanged", 128'(v), exp);
        rd(2'd3, v); check("R11 offset3 zero", 128'(v), 128'd0);
        rd(2'd1, v); check("R11 not busy", 128'(v), 128'd0);
        @(negedge clk);
        wr(2'd1, 32'd3);
        wait_idle();
        read_blk(blk);
        check("R11 key and plaintext unchanged", blk, m_aes(key, pt3));

        // R5/R10 random blocks
        for (int n = 0; n < 20; n++) begin
            logic [127:0] p;
            bit           rk;
            rk = (n == 0) || ($urandom_range(0, 3) == 0);
            if (rk) key = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            run_block(key, p, rk, rk ? "R5 random new key" : "R10 random kept key");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule